// File: doc/BRIEF.md
# RGB Panel Timing Generator

This block drives a parallel RGB display panel. From the system clock it derives a pixel clock and a one-cycle pixel strobe. Each pixel period it steps a horizontal counter and a vertical counter. From their positions it produces horizontal sync, vertical sync, a data-enable level and the pixel data. The data comes from a ready/valid source and passes through to the panel.

Software programs the block through a small write-only register port. The port holds the sync widths, porches and active size for both axes, the output mode and the output polarities. Every width and porch field stores its count minus one. The timing fields are double-buffered: a write lands in a shadow copy. The copy moves into the working set only on the last pixel of a frame, and only after software has requested it. Mode and polarity take effect on the next pixel.

Top module: `rgb_timing_gen`

## Requirements
- R1: While reset is asserted and after it, before the first pixel is shown: hsyncO and vsyncO are 1, deO is 0, dataO is 0, frameDone is 0 and updatePending is 0.
- R2: One pixel period is 2*HALF clocks. panelClk equals (second half of the period) XOR clock-edge bit (CTRL bit 7). The registered outputs change only on the clock edge that ends a period.
- R3: Each line runs sync, back porch, active, front porch, and so does each frame, counted in lines. Each segment lasts its field value plus one. In DE mode, deO is active for exactly (width+1)*(height+1) pixels per frame.
- R4: A frame lasts (vSync+vBack+height+vFront+4)*(hSync+hBack+width+hFront+4) pixel periods. frameDone is high for one clock, right after the last pixel of the last front-porch line is shown.
- R5: In HV mode (CTRL[1:0]=01), hsyncO is active for the first hSync+1 pixels of every line and vsyncO is active for the first vSync+1 lines of each frame. deO stays inactive.
- R6: In DE mode (CTRL[1:0]=00), hsyncO and vsyncO stay at their inactive level.
- R7: With a reserved mode code (10 or 11), hsyncO, vsyncO, deO and dataO hold their values and pixReady stays low.
- R8: The active level of deO is CTRL bit 4 (reset 1). The active levels of hsyncO and vsyncO are CTRL bits 5 and 6 (reset 0). CTRL bit 3 set inverts every bit of dataO, blanking included.
- R9: In modes 00/01, pixReady is high in the last clock of each active-pixel period. dataO then shows pixData if pixValid was high at that edge, and zero otherwise.
- R10: Writes to the vertical, horizontal or size registers do not change the running timing until a commit.
- R11: Writing 1 to CTRL bit 2 sets updatePending; writing 0 there has no effect. At the frame end the shadow values are committed, updatePending clears on that same edge, and the whole next frame uses the new values.
- R12: Register map (regAddr): 0 CTRL as above. 1 VERT: vSync [3:0], vBack [7:4], vFront [11:8]. 2 HORZ: hSync [7:0], hBack [15:8], hFront [23:16]. 3 SIZE: width-1 [10:0], height-1 [21:11]. Reset values: vertical 1/3/3, horizontal 1/3/3, width-1 15, height-1 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select |
| regWdata | input | 24 | Register write data |
| pixValid | input | 1 | Pixel source has data |
| pixData | input | DW | Pixel value from source |
| pixReady | output | 1 | Pixel consumed at this edge |
| panelClk | output | 1 | Pixel clock to panel |
| hsyncO | output | 1 | Horizontal sync |
| vsyncO | output | 1 | Vertical sync |
| deO | output | 1 | Data enable |
| dataO | output | DW | Pixel data to panel |
| frameDone | output | 1 | One-clock frame-end pulse |
| updatePending | output | 1 | Timing update requested, not yet committed |

## Verification
The assertions assume a frame of at least two pixel periods, so that frameDone cannot repeat on consecutive clocks; every field encoding guarantees this. They also assume that register writes arrive as single-clock strobes that are never held across reset. The stimulus keeps the timing fields small so that many frames fit in the run. It changes inputs only on the falling clock edge, draws each pixel value at random, and places register writes and update requests at random points, including near frame ends.

// File: rtl/rgb_timing_pkg.sv
package rgb_timing_pkg;

  localparam int VFW = 4;   // vertical field width
  localparam int HFW = 8;   // horizontal field width
  localparam int SZW = 11;  // active size field width
  localparam int RW  = 24;  // register write data width

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_VERT = 2'd1;
  localparam logic [1:0] ADDR_HORZ = 2'd2;
  localparam logic [1:0] ADDR_SIZE = 2'd3;

  localparam logic [1:0] MODE_DE = 2'b00;
  localparam logic [1:0] MODE_HV = 2'b01;

  typedef enum logic [1:0] {
    PH_SYNC  = 2'd0,
    PH_BACK  = 2'd1,
    PH_ACT   = 2'd2,
    PH_FRONT = 2'd3
  } phase_e;

  typedef struct packed {
    logic [VFW-1:0] vSync;
    logic [VFW-1:0] vBack;
    logic [VFW-1:0] vFront;
    logic [HFW-1:0] hSync;
    logic [HFW-1:0] hBack;
    logic [HFW-1:0] hFront;
    logic [SZW-1:0] width;
    logic [SZW-1:0] height;
  } timing_t;

  typedef struct packed {
    logic [1:0] mode;
    logic       dataInv;
    logic       deHigh;
    logic       hsHigh;
    logic       vsHigh;
    logic       clkFall;
  } outcfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic tick;
    logic secondHalf;
    logic inHSync;
    logic inVSync;
    logic inActive;
    logic frameEnd;
  } strobe_t;

  localparam timing_t TIMING_RST = '{
    vSync: 4'd1, vBack: 4'd3, vFront: 4'd3,
    hSync: 8'd1, hBack: 8'd3, hFront: 8'd3,
    width: 11'd15, height: 11'd7
  };

  localparam outcfg_t CFG_RST = '{
    mode: MODE_DE, dataInv: 1'b0, deHigh: 1'b1,
    hsHigh: 1'b0, vsHigh: 1'b0, clkFall: 1'b0
  };

endpackage

// File: rtl/rgb_axis_cnt.sv
module rgb_axis_cnt
  import rgb_timing_pkg::*;
#(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          step,
  input  logic [CW-1:0] lenSync,
  input  logic [CW-1:0] lenBack,
  input  logic [CW-1:0] lenAct,
  input  logic [CW-1:0] lenFront,
  output phase_e        phase,
  output logic          wrap
);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          atLim;

  always_comb begin
    case (phase)
      PH_SYNC: lim = lenSync;
      PH_BACK: lim = lenBack;
      PH_ACT:  lim = lenAct;
      default: lim = lenFront;
    endcase
  end

  assign atLim = (cnt == lim);
  assign wrap  = step & atLim & (phase == PH_FRONT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      phase <= PH_SYNC;
    end else if (step) begin
      if (atLim) begin
        cnt   <= '0;
        phase <= phase_e'(phase + 2'd1);
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

endmodule

// File: rtl/rgb_timing_ctrl.sv
module rgb_timing_ctrl
  import rgb_timing_pkg::*;
#(
  parameter int HALF = 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWe,
  input  logic [1:0]    regAddr,
  input  logic [RW-1:0] regWdata,
  output strobe_t       stb,
  output outcfg_t       cfg,
  output logic          updatePending,
  output logic          pixReady
);

  localparam int PDIV = 2 * HALF;
  localparam int PCW  = (PDIV > 1) ? $clog2(PDIV) : 1;

  logic [PCW-1:0] phaseCnt;
  logic           tick;
  timing_t        shadowT;
  timing_t        activeT;
  phase_e         hPh;
  phase_e         vPh;
  logic           lineEnd;
  logic           frameEnd;
  logic           modeOk;
  logic           updSet;

  // pixel period divider (R2)
  assign tick = (phaseCnt == PCW'(PDIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phaseCnt <= '0;
    else if (tick) phaseCnt <= '0;
    else phaseCnt <= phaseCnt + PCW'(1);
  end

  // horizontal then vertical position (R3, R4)
  rgb_axis_cnt #(.CW(SZW)) hCnt_i (
    .clk      (clk),
    .rstN     (rstN),
    .step     (tick),
    .lenSync  (SZW'(activeT.hSync)),
    .lenBack  (SZW'(activeT.hBack)),
    .lenAct   (activeT.width),
    .lenFront (SZW'(activeT.hFront)),
    .phase    (hPh),
    .wrap     (lineEnd)
  );

  rgb_axis_cnt #(.CW(SZW)) vCnt_i (
    .clk      (clk),
    .rstN     (rstN),
    .step     (lineEnd),
    .lenSync  (SZW'(activeT.vSync)),
    .lenBack  (SZW'(activeT.vBack)),
    .lenAct   (activeT.height),
    .lenFront (SZW'(activeT.vFront)),
    .phase    (vPh),
    .wrap     (frameEnd)
  );

  // register writes: shadow timing, live control (R12)
  assign updSet = regWe & (regAddr == ADDR_CTRL) & regWdata[2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowT <= TIMING_RST;
      cfg     <= CFG_RST;
    end else if (regWe) begin
      case (regAddr)
        ADDR_CTRL: begin
          cfg.mode    <= regWdata[1:0];
          cfg.dataInv <= regWdata[3];
          cfg.deHigh  <= regWdata[4];
          cfg.hsHigh  <= regWdata[5];
          cfg.vsHigh  <= regWdata[6];
          cfg.clkFall <= regWdata[7];
        end
        ADDR_VERT: begin
          shadowT.vSync  <= regWdata[VFW-1:0];
          shadowT.vBack  <= regWdata[2*VFW-1:VFW];
          shadowT.vFront <= regWdata[3*VFW-1:2*VFW];
        end
        ADDR_HORZ: begin
          shadowT.hSync  <= regWdata[HFW-1:0];
          shadowT.hBack  <= regWdata[2*HFW-1:HFW];
          shadowT.hFront <= regWdata[3*HFW-1:2*HFW];
        end
        default: begin
          shadowT.width  <= regWdata[SZW-1:0];
          shadowT.height <= regWdata[2*SZW-1:SZW];
        end
      endcase
    end
  end

  // commit at frame end when requested (R10, R11)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeT       <= TIMING_RST;
      updatePending <= 1'b0;
    end else begin
      if (frameEnd && updatePending) activeT <= shadowT;
      updatePending <= (updatePending & ~frameEnd) | updSet;
    end
  end

  assign modeOk = (cfg.mode == MODE_DE) | (cfg.mode == MODE_HV);

  assign stb.tick       = tick;
  assign stb.secondHalf = (phaseCnt >= PCW'(HALF));
  assign stb.inHSync    = (hPh == PH_SYNC);
  assign stb.inVSync    = (vPh == PH_SYNC);
  assign stb.inActive   = (hPh == PH_ACT) & (vPh == PH_ACT);
  assign stb.frameEnd   = frameEnd;

  assign pixReady = tick & stb.inActive & modeOk;

endmodule

// File: rtl/rgb_timing_dp.sv
module rgb_timing_dp
  import rgb_timing_pkg::*;
#(
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  outcfg_t       cfg,
  input  logic          pixValid,
  input  logic [DW-1:0] pixData,
  output logic          panelClk,
  output logic          hsyncO,
  output logic          vsyncO,
  output logic          deO,
  output logic [DW-1:0] dataO,
  output logic          frameDone
);

  logic          modeDe;
  logic          modeHv;
  logic [DW-1:0] pixSel;

  assign modeDe = (cfg.mode == MODE_DE);
  assign modeHv = (cfg.mode == MODE_HV);
  assign pixSel = (stb.inActive && pixValid) ? pixData : '0;

  // edge choice by phase inversion (R2)
  assign panelClk = stb.secondHalf ^ cfg.clkFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsyncO    <= 1'b1;
      vsyncO    <= 1'b1;
      deO       <= 1'b0;
      dataO     <= '0;
      frameDone <= 1'b0;
    end else begin
      frameDone <= stb.frameEnd;
      // reserved codes leave the outputs untouched (R7)
      if (stb.tick && (modeDe || modeHv)) begin
        hsyncO <= (modeHv && stb.inHSync) ? cfg.hsHigh : ~cfg.hsHigh;
        vsyncO <= (modeHv && stb.inVSync) ? cfg.vsHigh : ~cfg.vsHigh;
        deO    <= (modeDe && stb.inActive) ? cfg.deHigh : ~cfg.deHigh;
        dataO  <= pixSel ^ {DW{cfg.dataInv}};
      end
    end
  end

endmodule

// File: rtl/rgb_timing_gen.sv
module rgb_timing_gen
  import rgb_timing_pkg::*;
#(
  parameter int DW   = 24,
  parameter int HALF = 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWe,
  input  logic [1:0]    regAddr,
  input  logic [RW-1:0] regWdata,
  input  logic          pixValid,
  input  logic [DW-1:0] pixData,
  output logic          pixReady,
  output logic          panelClk,
  output logic          hsyncO,
  output logic          vsyncO,
  output logic          deO,
  output logic [DW-1:0] dataO,
  output logic          frameDone,
  output logic          updatePending
);

  strobe_t stb;
  outcfg_t cfg;
  logic    pixTick;

  assign pixTick = stb.tick;

  rgb_timing_ctrl #(.HALF(HALF)) ctrl_i (
    .clk           (clk),
    .rstN          (rstN),
    .regWe         (regWe),
    .regAddr       (regAddr),
    .regWdata      (regWdata),
    .stb           (stb),
    .cfg           (cfg),
    .updatePending (updatePending),
    .pixReady      (pixReady)
  );

  rgb_timing_dp #(.DW(DW)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .cfg       (cfg),
    .pixValid  (pixValid),
    .pixData   (pixData),
    .panelClk  (panelClk),
    .hsyncO    (hsyncO),
    .vsyncO    (vsyncO),
    .deO       (deO),
    .dataO     (dataO),
    .frameDone (frameDone)
  );

endmodule

// File: rtl/rgb_timing_chk.sv
module rgb_timing_chk #(
  parameter int DW = 24
) (
  input logic          clk,
  input logic          rstN,
  input logic          tick,
  input logic          frameDone,
  input logic          updatePending,
  input logic          hsyncO,
  input logic          vsyncO,
  input logic          deO,
  input logic [DW-1:0] dataO
);

  // R11
  upd_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(updatePending) |-> frameDone);

  // R4
  frame_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);

  // R4
  frame_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> $past(tick));

  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(tick) |-> ($stable(hsyncO) && $stable(vsyncO) && $stable(deO) && $stable(dataO)));

endmodule

bind rgb_timing_gen rgb_timing_chk #(.DW(DW)) chk_i (
  .clk           (clk),
  .rstN          (rstN),
  .tick          (pixTick),
  .frameDone     (frameDone),
  .updatePending (updatePending),
  .hsyncO        (hsyncO),
  .vsyncO        (vsyncO),
  .deO           (deO),
  .dataO         (dataO)
);

// File: tb/rgb_timing_gen_tb_top.sv
`timescale 1ns/1ps
module rgb_timing_gen_tb_top;

  localparam int DW   = 24;
  localparam int HALF = 1;
  localparam int PDIV = 2 * HALF;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWe = 1'b0;
  logic [1:0]    regAddr = '0;
  logic [23:0]   regWdata = '0;
  logic          pixValid = 1'b0;
  logic [DW-1:0] pixData = '0;
  logic          pixReady, panelClk, hsyncO, vsyncO, deO, frameDone, updatePending;
  logic [DW-1:0] dataO;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rgb_timing_gen #(.DW(DW), .HALF(HALF)) dut_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .pixValid(pixValid), .pixData(pixData), .pixReady(pixReady), .panelClk(panelClk),
    .hsyncO(hsyncO), .vsyncO(vsyncO), .deO(deO), .dataO(dataO),
    .frameDone(frameDone), .updatePending(updatePending)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int edgeCnt, mCol, mLine;
  int mVs, mVb, mVf, mHs, mHb, mHf, mW, mH;
  int sVs, sVb, sVf, sHs, sHb, sHf, sW, sH;
  int cMode;
  bit cDataInv, cDeHigh, cHsHigh, cVsHigh, cClkFall, mPend;
  bit expHs, expVs, expDe, expFd;
  logic [DW-1:0] expData;

  function automatic int lineLen();
    return mHs + mHb + mW + mHf + 4;
  endfunction
  function automatic int frameLines();
    return mVs + mVb + mH + mVf + 4;
  endfunction
  function automatic bit isAct(int col, int line);
    return (col >= mHs + mHb + 2) && (col < mHs + mHb + mW + 3) &&
           (line >= mVs + mVb + 2) && (line < mVs + mVb + mH + 3);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      edgeCnt = 0; mCol = 0; mLine = 0;
      mVs = 1; mVb = 3; mVf = 3; mHs = 1; mHb = 3; mHf = 3; mW = 15; mH = 7;
      sVs = 1; sVb = 3; sVf = 3; sHs = 1; sHb = 3; sHf = 3; sW = 15; sH = 7;
      cMode = 0; cDataInv = 0; cDeHigh = 1; cHsHigh = 0; cVsHigh = 0; cClkFall = 0; mPend = 0;
      expHs = 1; expVs = 1; expDe = 0; expFd = 0; expData = '0;
    end else begin
      edgeCnt++;
      expFd = 0;
      if (edgeCnt % PDIV == 0) begin
        bit act, last;
        act = isAct(mCol, mLine);
        if (cMode == 0 || cMode == 1) begin
          expHs = (cMode == 1 && mCol <= mHs) ? cHsHigh : !cHsHigh;
          expVs = (cMode == 1 && mLine <= mVs) ? cVsHigh : !cVsHigh;
          expDe = (cMode == 0 && act) ? cDeHigh : !cDeHigh;
          expData = ((act && pixValid) ? pixData : '0) ^ {DW{cDataInv}};
        end
        last = (mCol == lineLen() - 1) && (mLine == frameLines() - 1);
        if (mCol == lineLen() - 1) begin
          mCol = 0;
          mLine = last ? 0 : mLine + 1;
        end else mCol++;
        if (last) begin
          expFd = 1;
          if (mPend) begin
            mVs = sVs; mVb = sVb; mVf = sVf; mHs = sHs; mHb = sHb; mHf = sHf; mW = sW; mH = sH;
            mPend = 0;
          end
        end
      end
      if (regWe) begin
        case (regAddr)
          2'd0: begin
            cMode = int'(regWdata[1:0]);
            if (regWdata[2]) mPend = 1;
            cDataInv = regWdata[3]; cDeHigh = regWdata[4];
            cHsHigh = regWdata[5]; cVsHigh = regWdata[6]; cClkFall = regWdata[7];
          end
          2'd1: begin
            sVs = int'(regWdata[3:0]); sVb = int'(regWdata[7:4]); sVf = int'(regWdata[11:8]);
          end
          2'd2: begin
            sHs = int'(regWdata[7:0]); sHb = int'(regWdata[15:8]); sHf = int'(regWdata[23:16]);
          end
          default: begin
            sW = int'(regWdata[10:0]); sH = int'(regWdata[21:11]);
          end
        endcase
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      string syncTag;
      bit expReady;
      syncTag = (cMode == 1) ? "R5" : (cMode == 0) ? "R6" : "R7";
      expReady = ((edgeCnt % PDIV) == PDIV - 1) && isAct(mCol, mLine) && (cMode == 0 || cMode == 1);
      chk(syncTag, "hsync", 32'(hsyncO), 32'(expHs));
      chk(syncTag, "vsync", 32'(vsyncO), 32'(expVs));
      chk(cMode > 1 ? "R7" : (cDeHigh ? "R3" : "R8"), "de", 32'(deO), 32'(expDe));
      chk(cDataInv ? "R8" : "R9", "data", 32'(dataO), 32'(expData));
      chk("R9", "pixReady", 32'(pixReady), 32'(expReady));
      chk("R2", "panelClk", 32'(panelClk), 32'(((edgeCnt % PDIV) >= HALF) ^ cClkFall));
      chk("R4", "frameDone", 32'(frameDone), 32'(expFd));
      chk("R11", "updatePending", 32'(updatePending), 32'(mPend));
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(input bit we, input logic [1:0] a, input logic [23:0] d);
    @(negedge clk);
    pixValid = 1'($urandom);
    pixData  = DW'($urandom);
    regWe    = we;
    regAddr  = a;
    regWdata = d;
  endtask

  task automatic idle();
    step(1'b0, 2'd0, 24'd0);
  endtask

  task automatic wr(input logic [1:0] a, input logic [23:0] d);
    step(1'b1, a, d);
    idle();
  endtask

  task automatic waitFrame(output int per, output int deHi, output int hsHi, output int vsHi);
    per = 0; deHi = 0; hsHi = 0; vsHi = 0;
    for (int i = 0; i < 6000; i++) begin
      idle();
      per++;
      if (deO) deHi++;
      if (hsyncO) hsHi++;
      if (vsyncO) vsHi++;
      if (frameDone) break;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL R4 watchdog expired actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int per, deHi, hsHi, vsHi, seedDummy;
    logic [DW-1:0] holdData;
    logic holdHs, holdVs, holdDe;
    seedDummy = $urandom(32'd20240);
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1", "hsync rst", 32'(hsyncO), 32'd1);
    chk("R1", "vsync rst", 32'(vsyncO), 32'd1);
    chk("R1", "de rst", 32'(deO), 32'd0);
    chk("R1", "data rst", 32'(dataO), 32'd0);
    chk("R1", "frameDone rst", 32'(frameDone), 32'd0);
    chk("R1", "upd rst", 32'(updatePending), 32'd0);
    rstN = 1'b1;
    idle();
    chk("R1", "data before first pixel", 32'(dataO), 32'd0);

    // default frame: 18 lines x 26 pixels x 2 clocks
    waitFrame(per, deHi, hsHi, vsHi);
    waitFrame(per, deHi, hsHi, vsHi);
    chk("R4", "default frame period", 32'(per), 32'd936);
    chk("R3", "default de count", 32'(deHi), 32'd256);
    chk("R6", "DE mode hsync high", 32'(hsHi), 32'd936);

    // R10: shadow writes only
    wr(2'd1, 24'h000210);
    wr(2'd2, 24'h020100);
    wr(2'd3, {2'b0, 11'd3, 11'd7});
    waitFrame(per, deHi, hsHi, vsHi);
    waitFrame(per, deHi, hsHi, vsHi);
    chk("R10", "period unchanged", 32'(per), 32'd936);
    chk("R10", "de unchanged", 32'(deHi), 32'd256);

    // R11: writing 0 to update bit is ignored
    wr(2'd0, 24'h000010);
    chk("R11", "zero write ignored", 32'(updatePending), 32'd0);
    wr(2'd0, 24'h000014);
    chk("R11", "request pending", 32'(updatePending), 32'd1);
    waitFrame(per, deHi, hsHi, vsHi);
    chk("R11", "cleared at frame end", 32'(updatePending), 32'd0);
    waitFrame(per, deHi, hsHi, vsHi);
    chk("R12", "new frame period", 32'(per), 32'd280);
    chk("R3", "new de count", 32'(deHi), 32'd64);

    // R5: HV mode
    wr(2'd0, 24'h000011);
    waitFrame(per, deHi, hsHi, vsHi);
    waitFrame(per, deHi, hsHi, vsHi);
    chk("R5", "hsync inactive cycles", 32'(hsHi), 32'd260);
    chk("R5", "vsync inactive cycles", 32'(vsHi), 32'd252);
    chk("R5", "de held low", 32'(deHi), 32'd0);

    // R7: reserved code freezes outputs
    wr(2'd0, 24'h000012);
    idle(); idle();
    holdHs = hsyncO; holdVs = vsyncO; holdDe = deO; holdData = dataO;
    repeat (300) idle();
    chk("R7", "hsync frozen", 32'(hsyncO), 32'(holdHs));
    chk("R7", "vsync frozen", 32'(vsyncO), 32'(holdVs));
    chk("R7", "de frozen", 32'(deO), 32'(holdDe));
    chk("R7", "data frozen", 32'(dataO), 32'(holdData));

    // R8: polarity swap in DE mode
    wr(2'd0, 24'h0000E8);
    waitFrame(per, deHi, hsHi, vsHi);
    waitFrame(per, deHi, hsHi, vsHi);
    chk("R8", "de active low", 32'(deHi), 32'd216);
    chk("R8", "hsync inactive low", 32'(hsHi), 32'd0);
    chk("R8", "vsync inactive low", 32'(vsHi), 32'd0);

    // random section
    for (int it = 0; it < 16; it++) begin
      logic [23:0] c;
      c = 24'($urandom) & 24'h0000FB;
      if ($urandom % 4 != 0) c[1] = 1'b0;
      if ($urandom % 2 == 0) c[2] = 1'b1;
      wr(2'd1, {12'd0, 4'($urandom % 4), 4'($urandom % 4), 4'($urandom % 4)});
      repeat ($urandom % 50) idle();
      wr(2'd2, {5'd0, 3'($urandom), 5'd0, 3'($urandom), 5'd0, 3'($urandom)});
      wr(2'd3, {2'd0, 11'($urandom % 8), 11'($urandom % 16)});
      wr(2'd0, c);
      repeat (1000 + $urandom % 1500) idle();
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule